// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches a serial receiver's holding queue and flags the case where data sits unread and no new characters arrive for too long. It counts bit periods, delivered as a one-cycle tick from the baud generator, but only while it is enabled and the receive queue holds at least one entry. When the count reaches a programmable limit, a sticky interrupt status bit is set. Software clears that bit through a dedicated clear strobe.

Both kinds of activity restart the count from zero: a freshly assembled character arriving from the receiver, and a software read of the receive data. The timer therefore fires only on real inactivity, never while traffic or draining is in progress. Dropping the enable also zeroes the count, and a limit of zero keeps the timer from ever firing.

Top module: `rx_idle_timer`

## Requirements
- R1: After a synchronous reset, the interrupt status `idle_irq` is 0 and the internal count is 0.
- R2: The count advances by one only in a cycle where `bit_tick`, `enable` and `rxq_nonempty` are all 1 and no restart event is present.
- R3: With a limit L > 0 held constant, `idle_irq` becomes 1 on the clock edge that samples the L-th qualifying tick after the last restart. It is visible from the following cycle.
- R4: `idle_irq` stays 0 while fewer than L qualifying ticks have occurred since the last restart.
- R5: A cycle with `rx_char_done` = 1 sets the count to 0 and takes priority over a tick in the same cycle.
- R6: A cycle with `rx_data_read` = 1 sets the count to 0 and takes priority over a tick in the same cycle.
- R7: When `idle_limit` = 0, the count does not advance and `idle_irq` never becomes set.
- R8: Once set, `idle_irq` stays 1 until a cycle with `irq_clear` = 1. If firing and clearing coincide in one cycle, the status remains 1.
- R9: Firing resets the count to 0, so a following firing needs another L qualifying ticks.
- R10: A cycle with `enable` = 0 sets the count to 0, and ticks in that cycle are ignored.
- R11: Ticks while `rxq_nonempty` = 0 leave the count unchanged. They neither advance it nor reset it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| enable | input | 1 | Timer enable; 0 holds the count at zero |
| idle_limit | input | 24 | Timeout in bit periods; 0 disables firing |
| rxq_nonempty | input | 1 | Receive queue holds at least one entry |
| rx_char_done | input | 1 | Strobe: a character was received |
| rx_data_read | input | 1 | Strobe: software read the receive data |
| irq_clear | input | 1 | Strobe: clear the interrupt status |
| idle_irq | output | 1 | Sticky timeout interrupt status |

## Verification
The bench runs a behavioural model beside the design and compares the status on every cycle. It aims at the edges of the limit: firing one tick early or one tick late would show up as a mismatch on the L-1 or L+1 tick. Restart strobes are placed on the same cycle as a tick; a design that let the tick win would fire early. The bench also covers a clear arriving on the firing cycle, which a clear-wins design would lose, and a zero limit, where a wrap-style comparison would fire spuriously. Ticks are sent while the queue is empty, which catches a design that either counts them or resets on them.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

    localparam int TV_W_DEF = 24;

    typedef enum logic [1:0] {
        CNT_HOLD    = 2'd0,
        CNT_STEP    = 2'd1,
        CNT_RESTART = 2'd2,
        CNT_WRAP    = 2'd3
    } cnt_op_e;

    typedef struct packed {
        cnt_op_e op;
        logic    fire;
    } idle_ctrl_t;

    function automatic logic any_restart(input logic en, input logic char_done,
                                         input logic data_read);
        return (!en) || char_done || data_read;
    endfunction

endpackage

// File: rtl/rx_idle_ctrl.sv
module rx_idle_ctrl
    import rx_idle_pkg::*;
#(
    parameter int TV_W = TV_W_DEF
) (
    input  logic              enable,
    input  logic              bit_tick,
    input  logic              rxq_nonempty,
    input  logic              rx_char_done,
    input  logic              rx_data_read,
    input  logic [TV_W-1:0]   idle_limit,
    input  logic [TV_W-1:0]   cnt,
    output idle_ctrl_t        ctrl
);

    localparam int EXT_W = TV_W + 1;

    logic             qualified;
    logic [EXT_W-1:0] next_cnt;
    logic             at_limit;

    always_comb begin
        qualified = bit_tick && rxq_nonempty && (idle_limit != '0);
        next_cnt  = {1'b0, cnt} + EXT_W'(1);
        at_limit  = next_cnt >= {1'b0, idle_limit};
    end

    always_comb begin
        ctrl.op   = CNT_HOLD;
        ctrl.fire = 1'b0;
        if (any_restart(enable, rx_char_done, rx_data_read)) begin
            ctrl.op = CNT_RESTART;
        end else if (qualified) begin
            if (at_limit) begin
                ctrl.op   = CNT_WRAP;
                ctrl.fire = 1'b1;
            end else begin
                ctrl.op = CNT_STEP;
            end
        end
    end

endmodule

// File: rtl/rx_idle_counter.sv
module rx_idle_counter
    import rx_idle_pkg::*;
#(
    parameter int TV_W = TV_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  cnt_op_e         op,
    output logic [TV_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (op)
                CNT_STEP:    cnt <= cnt + TV_W'(1);
                CNT_RESTART: cnt <= '0;
                CNT_WRAP:    cnt <= '0;
                default:     cnt <= cnt;
            endcase
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> cnt == '0) // R1
        else $error("count not zero after reset");
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        op == CNT_HOLD |=> $stable(cnt)) // R11
        else $error("count moved on hold");
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        op == CNT_WRAP |=> cnt == '0) // R9
        else $error("count not zero after firing");

endmodule

// File: rtl/rx_idle_status.sv
module rx_idle_status (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic irq_clear,
    output logic idle_irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_irq <= 1'b0;
        end else if (fire) begin
            idle_irq <= 1'b1;
        end else if (irq_clear) begin
            idle_irq <= 1'b0;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (idle_irq && !irq_clear) |=> idle_irq) // R8
        else $error("status dropped without clear");
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (fire && irq_clear) |=> idle_irq) // R8
        else $error("clear beat simultaneous fire");

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import rx_idle_pkg::*;
#(
    parameter int TV_W = TV_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_tick,
    input  logic            enable,
    input  logic [TV_W-1:0] idle_limit,
    input  logic            rxq_nonempty,
    input  logic            rx_char_done,
    input  logic            rx_data_read,
    input  logic            irq_clear,
    output logic            idle_irq
);

    idle_ctrl_t      ctrl;
    logic [TV_W-1:0] cnt;

    rx_idle_ctrl #(.TV_W(TV_W)) u_ctrl (
        .enable       (enable),
        .bit_tick     (bit_tick),
        .rxq_nonempty (rxq_nonempty),
        .rx_char_done (rx_char_done),
        .rx_data_read (rx_data_read),
        .idle_limit   (idle_limit),
        .cnt          (cnt),
        .ctrl         (ctrl)
    );

    rx_idle_counter #(.TV_W(TV_W)) u_counter (
        .clk (clk),
        .rst (rst),
        .op  (ctrl.op),
        .cnt (cnt)
    );

    rx_idle_status u_status (
        .clk       (clk),
        .rst       (rst),
        .fire      (ctrl.fire),
        .irq_clear (irq_clear),
        .idle_irq  (idle_irq)
    );

    AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !enable |=> cnt == '0) // R10
        else $error("count not zero while disabled");
    AST_CHAR_RESTART: assert property (@(posedge clk) disable iff (rst)
        rx_char_done |=> cnt == '0) // R5
        else $error("char did not restart count");
    AST_READ_RESTART: assert property (@(posedge clk) disable iff (rst)
        rx_data_read |=> cnt == '0) // R6
        else $error("read did not restart count");
    AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (idle_limit == '0 && !idle_irq) |=> !idle_irq) // R7
        else $error("fired with zero limit");
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_irq) |-> $past(bit_tick && rxq_nonempty && enable)) // R3
        else $error("status rose without qualifying tick");
    AST_EMPTY_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (!rxq_nonempty && enable && !rx_char_done && !rx_data_read) |=> $stable(cnt)) // R11
        else $error("count moved with empty queue");

endmodule

// File: tb/rx_idle_timer_tb.sv
module rx_idle_timer_tb;

    localparam int TV_W = 24;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bit_tick = 1'b0;
    logic            enable = 1'b0;
    logic [TV_W-1:0] idle_limit = '0;
    logic            rxq_nonempty = 1'b0;
    logic            rx_char_done = 1'b0;
    logic            rx_data_read = 1'b0;
    logic            irq_clear = 1'b0;
    logic            idle_irq;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    int    m_cnt = 0;
    bit    m_irq = 1'b0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    rx_idle_timer #(.TV_W(TV_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .enable       (enable),
        .idle_limit   (idle_limit),
        .rxq_nonempty (rxq_nonempty),
        .rx_char_done (rx_char_done),
        .rx_data_read (rx_data_read),
        .irq_clear    (irq_clear),
        .idle_irq     (idle_irq)
    );

    // Behavioural reference: state after each edge
    always @(posedge clk) begin
        bit fire;
        fire = 1'b0;
        if (rst) begin
            m_cnt = 0;
            m_irq = 1'b0;
        end else begin
            if (!enable || rx_char_done || rx_data_read) begin
                m_cnt = 0;
            end else if (bit_tick && rxq_nonempty && idle_limit != 0) begin
                if (m_cnt + 1 >= int'(idle_limit)) begin
                    m_cnt = 0;
                    fire = 1'b1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (fire) m_irq = 1'b1;
            else if (irq_clear) m_irq = 1'b0;
        end
    end

    task automatic check(input bit got, input bit exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: idle_irq=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, then return for driving
    task automatic cyc();
        @(negedge clk);
        check(idle_irq, m_irq, cur_req);
    endtask

    task automatic idle_inputs();
        bit_tick = 0; rx_char_done = 0; rx_data_read = 0; irq_clear = 0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; cyc(); bit_tick = 0; cyc();
        end
    endtask

    task automatic do_clear();
        irq_clear = 1; cyc(); irq_clear = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        cyc();
        check(idle_irq, 1'b0, "R1");

        // R3/R4: limit 4, ticks every other cycle
        cur_req = "R4";
        enable = 1; rxq_nonempty = 1; idle_limit = 4;
        tick_n(3);
        check(idle_irq, 1'b0, "R4");
        cur_req = "R3";
        tick_n(1);
        check(idle_irq, 1'b1, "R3");

        // R8: sticky without clear, even with more inactivity
        cur_req = "R8";
        repeat (5) cyc();
        check(idle_irq, 1'b1, "R8");
        do_clear(); cyc();
        check(idle_irq, 1'b0, "R8");

        // R9: count restarted at firing; next firing after 4 more ticks
        cur_req = "R9";
        do_clear();
        tick_n(3);
        check(idle_irq, 1'b0, "R9");
        tick_n(1);
        check(idle_irq, 1'b1, "R9");
        do_clear(); cyc();

        // R2: consecutive ticks every cycle
        cur_req = "R2";
        idle_limit = 6;
        bit_tick = 1; repeat (5) cyc(); bit_tick = 0; cyc();
        check(idle_irq, 1'b0, "R2");
        bit_tick = 1; cyc(); bit_tick = 0; cyc();
        check(idle_irq, 1'b1, "R2");
        do_clear(); cyc();

        // R5: char strobe restarts, with tick in same cycle
        cur_req = "R5";
        idle_limit = 4;
        tick_n(3);
        bit_tick = 1; rx_char_done = 1; cyc(); idle_inputs(); cyc();
        check(idle_irq, 1'b0, "R5");
        tick_n(3);
        check(idle_irq, 1'b0, "R5");
        tick_n(1);
        check(idle_irq, 1'b1, "R5");
        do_clear(); cyc();

        // R6: software read restarts
        cur_req = "R6";
        tick_n(3);
        bit_tick = 1; rx_data_read = 1; cyc(); idle_inputs(); cyc();
        tick_n(3);
        check(idle_irq, 1'b0, "R6");
        tick_n(1);
        check(idle_irq, 1'b1, "R6");
        do_clear(); cyc();

        // R11: empty queue ticks neither count nor reset
        cur_req = "R11";
        tick_n(2);
        rxq_nonempty = 0;
        tick_n(10);
        check(idle_irq, 1'b0, "R11");
        rxq_nonempty = 1;
        tick_n(1);
        check(idle_irq, 1'b0, "R11");
        tick_n(1);
        check(idle_irq, 1'b1, "R11");
        do_clear(); cyc();

        // R10: disable zeroes count, ticks ignored
        cur_req = "R10";
        tick_n(3);
        enable = 0;
        tick_n(6);
        check(idle_irq, 1'b0, "R10");
        enable = 1;
        tick_n(3);
        check(idle_irq, 1'b0, "R10");
        tick_n(1);
        check(idle_irq, 1'b1, "R10");
        do_clear(); cyc();

        // R8: clear coinciding with the firing tick keeps status set
        cur_req = "R8";
        tick_n(3);
        bit_tick = 1; irq_clear = 1; cyc(); idle_inputs(); cyc();
        check(idle_irq, 1'b1, "R8");
        do_clear(); cyc();

        // R7: zero limit never fires
        cur_req = "R7";
        idle_limit = 0;
        tick_n(40);
        check(idle_irq, 1'b0, "R7");

        // Mixed pattern, compared cycle by cycle against the model
        cur_req = "R2";
        idle_limit = 3;
        for (int i = 0; i < 400; i++) begin
            bit_tick     = (i % 3) != 1;
            rxq_nonempty = (i % 17) != 0;
            rx_char_done = (i % 23) == 5;
            rx_data_read = (i % 29) == 7;
            irq_clear    = (i % 13) == 2;
            enable       = (i % 41) != 9;
            cyc();
        end
        idle_inputs();
        cyc();

        // R1: reset returns status to zero
        cur_req = "R1";
        rst = 1; cyc(); rst = 0; cyc();
        check(idle_irq, 1'b0, "R1");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule